// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block tracks exceptions through an in-order pipeline of five stages (fetch, decode, execute, memory, commit) and decides which instructions may write back. It holds the four registered stage slots after fetch. Each slot carries a valid bit, a program counter, a destination tag, a result value, an exception flag with a cause, and a cancel bit. Instruction decoding, arithmetic, memory access and the register file sit outside the block. The surrounding logic presents the fetched instruction, raises fault or overflow reports against whatever occupies fetch, execute or memory in that cycle, and supplies the execute result.

When an instruction that is still live reports a fault, every younger slot has its cancel bit set. The faulting instruction is marked with its cause and carries on to commit. At commit, a live non-faulting slot produces a register write. A live faulting slot produces no write, and instead latches its program counter and cause into status outputs. A fetch redirect to a fixed handler address is raised either when the faulting instruction commits, or in the very cycle the fault is detected. A parameter chooses between the two.

Top module: `exc_commit_ctrl`

## Requirements
- R1: With no faults, every instruction fetched in cycle c writes back in cycle c+4 with its own tag and the execute result supplied for it, in program order.
- R2: Faults are accepted from three places: fetch (`if_fault_i`), execute (`ex_ovf_i`) and memory (`mem_fault_i`). A report against a slot that is invalid, cancelled or already faulting has no effect.
- R3: All instructions older than a faulting instruction write back before the exception is taken.
- R4: All instructions younger than a faulting instruction are cancelled and none of them writes back.
- R5: A slot whose cancel bit is set never asserts `wb_en_o`.
- R6: The faulting instruction itself performs no write-back.
- R7: With `EARLY_REDIRECT`=0, `redirect_o` is asserted only in the cycle the faulting instruction is at commit, which is four cycles after it was fetched.
- R8: With `EARLY_REDIRECT`=1, `redirect_o` is asserted in the same cycle a fault is detected: fetch cycle +0 for a fetch fault, +2 for an overflow, +3 for a data fault.
- R9: When a faulting instruction commits, `epc_o` takes its program counter and `cause_o` its cause on the next edge: 0 = instruction page fault, 1 = overflow, 2 = data page fault. The status outputs otherwise hold.
- R10: When several stages report in the same cycle, the report from the oldest instruction (furthest down the pipeline) wins.
- R11: In early mode, a fault found later in an older instruction cancels a younger one already redirected, redirects again, and its own cause is the one recorded.
- R12: `redirect_pc_o` always equals `HANDLER_PC`. Instructions fetched from there after the redirect are not cancelled and write back normally.
- R13: During reset, `wb_en_o` and `redirect_o` are low and `epc_o` and `cause_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_valid_i | input | 1 | An instruction is being fetched this cycle |
| if_pc_i | input | XLEN | Program counter of the fetched instruction |
| if_tag_i | input | TAG_W | Destination tag of the fetched instruction |
| if_fault_i | input | 1 | Instruction page fault on the fetched instruction |
| ex_ovf_i | input | 1 | Overflow on the instruction in execute |
| ex_result_i | input | XLEN | Result for the instruction in execute |
| mem_fault_i | input | 1 | Data page fault on the instruction in memory |
| wb_en_o | output | 1 | Register write enable at commit |
| wb_tag_o | output | TAG_W | Destination tag of the write |
| wb_data_o | output | XLEN | Data of the write |
| redirect_o | output | 1 | Redirect fetch to the handler |
| redirect_pc_o | output | XLEN | Handler address |
| epc_o | output | XLEN | Latched program counter of the last taken exception |
| cause_o | output | 2 | Latched cause of the last taken exception |

## Verification
The hardest situation to create from the ports is an older instruction faulting after a younger one has already faulted and, in early mode, already redirected fetch. The stimulus places a fetch fault on one address and an overflow on the address just before it, timed so that the overflow reaches execute one cycle after the younger fetch fault. The same-cycle priority case is built the same way: a data fault and an overflow land on adjacent instructions in the same cycle. Both redirect modes run side by side on the same fault plans, each with its own fetch model that follows its own redirects.

// File: rtl/exc_pkg.sv
package exc_pkg;

    parameter int unsigned XLEN   = 32;
    parameter int unsigned TAG_W  = 8;
    // registered slots after fetch: decode, execute, memory, commit
    parameter int unsigned NSTAGE = 4;

    localparam int ST_DEC = 0;
    localparam int ST_EXE = 1;
    localparam int ST_MEM = 2;
    localparam int ST_COM = 3;

    typedef enum logic [1:0] {
        CAUSE_IFETCH = 2'd0,
        CAUSE_OVF    = 2'd1,
        CAUSE_DFAULT = 2'd2
    } cause_e;

    typedef struct packed {
        logic              valid;
        logic              cancel;
        logic              exc;
        cause_e            cause;
        logic [XLEN-1:0]   pc;
        logic [TAG_W-1:0]  tag;
        logic [XLEN-1:0]   data;
    } slot_t;

    // a slot that can still raise a fault
    function automatic logic slot_live(slot_t s);
        return s.valid && !s.cancel && !s.exc;
    endfunction

    // cause attached to a slot as it leaves source position idx
    // (0 = fetch input, 1 = decode, 2 = execute, 3 = memory)
    function automatic cause_e src_cause(int idx);
        case (idx)
            0:       return CAUSE_IFETCH;
            2:       return CAUSE_OVF;
            default: return CAUSE_DFAULT;
        endcase
    endfunction

endpackage

// File: rtl/exc_detect.sv
module exc_detect
    import exc_pkg::*;
(
    input  logic [NSTAGE-1:0] src_fault,
    output logic [NSTAGE-1:0] kill,
    output logic [NSTAGE-1:0] mark,
    output logic              any_det
);
    // src_fault[i]: the slot leaving source position i is live and faulting.
    // A higher index is an older instruction; it cancels all lower ones.
    always_comb begin
        for (int i = 0; i < NSTAGE; i++) begin
            kill[i] = 1'b0;
            for (int j = i + 1; j < NSTAGE; j++) begin
                kill[i] = kill[i] | src_fault[j];
            end
            mark[i] = src_fault[i] && !kill[i];
        end
        any_det = |src_fault;
    end

endmodule

// File: rtl/exc_stage_pipe.sv
module exc_stage_pipe
    import exc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  slot_t                  fetch_s,
    input  logic [NSTAGE-1:0]      kill,
    input  logic [NSTAGE-1:0]      mark,
    input  logic [XLEN-1:0]        ex_result,
    output slot_t [NSTAGE-1:0]     st
);
    for (genvar gi = 0; gi < NSTAGE; gi++) begin : g_stage
        slot_t src;
        slot_t nxt;

        if (gi == 0) begin : g_first
            assign src = fetch_s;
        end else begin : g_chain
            assign src = st[gi-1];
        end

        always_comb begin
            nxt = src;
            if (kill[gi]) begin
                nxt.cancel = 1'b1;
            end
            if (mark[gi]) begin
                nxt.exc   = 1'b1;
                nxt.cause = src_cause(gi);
            end
            if (gi == ST_MEM) begin
                nxt.data = ex_result;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st[gi] <= '0;
            end else begin
                st[gi] <= nxt;
            end
        end
    end

endmodule

// File: rtl/exc_commit.sv
module exc_commit
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER_PC     = 32'h0000_0100,
    parameter bit              EARLY_REDIRECT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_t             com_s,
    input  logic              any_det,
    output logic              wb_en,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [XLEN-1:0]   wb_data,
    output logic              redirect,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              squash_fetch,
    output logic [XLEN-1:0]   epc,
    output logic [1:0]        cause
);
    logic commit_live;
    logic commit_exc;

    assign commit_live = com_s.valid && !com_s.cancel;
    assign commit_exc  = commit_live && com_s.exc;
    assign wb_en       = commit_live && !com_s.exc;
    assign wb_tag      = com_s.tag;
    assign wb_data     = com_s.data;
    assign redirect_pc = HANDLER_PC;

    if (EARLY_REDIRECT) begin : g_early
        assign redirect     = any_det;
        assign squash_fetch = 1'b0;
    end else begin : g_late
        logic pend_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= 1'b0;
            end else if (commit_exc) begin
                pend_q <= 1'b0;
            end else if (any_det) begin
                pend_q <= 1'b1;
            end
        end
        assign redirect     = commit_exc;
        assign squash_fetch = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            epc   <= '0;
            cause <= '0;
        end else if (commit_exc) begin
            epc   <= com_s.pc;
            cause <= com_s.cause;
        end
    end

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER_PC     = 32'h0000_0100,
    parameter bit              EARLY_REDIRECT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              if_valid_i,
    input  logic [XLEN-1:0]   if_pc_i,
    input  logic [TAG_W-1:0]  if_tag_i,
    input  logic              if_fault_i,
    input  logic              ex_ovf_i,
    input  logic [XLEN-1:0]   ex_result_i,
    input  logic              mem_fault_i,
    output logic              wb_en_o,
    output logic [TAG_W-1:0]  wb_tag_o,
    output logic [XLEN-1:0]   wb_data_o,
    output logic              redirect_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [1:0]        cause_o
);
    slot_t               fetch_s;
    slot_t [NSTAGE-1:0]  st;
    slot_t               com_s;
    logic [NSTAGE-1:0]   src_fault;
    logic [NSTAGE-1:0]   kill;
    logic [NSTAGE-1:0]   mark;
    logic                any_det;
    logic                squash_fetch;

    always_comb begin
        fetch_s        = '0;
        fetch_s.valid  = if_valid_i;
        fetch_s.cancel = squash_fetch;
        fetch_s.pc     = if_pc_i;
        fetch_s.tag    = if_tag_i;
    end

    assign com_s = st[ST_COM];

    // fault reports lined up by source position of the slot they hit
    assign src_fault[0]          = slot_live(fetch_s)   && if_fault_i;
    assign src_fault[ST_DEC + 1] = 1'b0;
    assign src_fault[ST_EXE + 1] = slot_live(st[ST_EXE]) && ex_ovf_i;
    assign src_fault[ST_MEM + 1] = slot_live(st[ST_MEM]) && mem_fault_i;

    exc_detect u_detect (
        .src_fault (src_fault),
        .kill      (kill),
        .mark      (mark),
        .any_det   (any_det)
    );

    exc_stage_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .fetch_s   (fetch_s),
        .kill      (kill),
        .mark      (mark),
        .ex_result (ex_result_i),
        .st        (st)
    );

    exc_commit #(
        .HANDLER_PC     (HANDLER_PC),
        .EARLY_REDIRECT (EARLY_REDIRECT)
    ) u_commit (
        .clk          (clk),
        .rst          (rst),
        .com_s        (com_s),
        .any_det      (any_det),
        .wb_en        (wb_en_o),
        .wb_tag       (wb_tag_o),
        .wb_data      (wb_data_o),
        .redirect     (redirect_o),
        .redirect_pc  (redirect_pc_o),
        .squash_fetch (squash_fetch),
        .epc          (epc_o),
        .cause        (cause_o)
    );

endmodule

// File: rtl/exc_commit_ctrl_chk.sv
module exc_commit_ctrl_chk
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER = 32'h0000_0100,
    parameter bit              EARLY   = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             c_valid,
    input logic             c_cancel,
    input logic             c_exc,
    input logic [XLEN-1:0]  c_pc,
    input logic [1:0]       c_cause,
    input logic             any_det,
    input logic             wb_en,
    input logic             redirect,
    input logic [XLEN-1:0]  redirect_pc,
    input logic [XLEN-1:0]  epc,
    input logic [1:0]       cause
);
    AST_WB_NOT_CANCELLED: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (c_valid && !c_cancel)); // R5

    AST_WB_NOT_FAULTING: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> !c_exc); // R6

    AST_LATE_REDIRECT_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (!EARLY && redirect) |-> (c_valid && c_exc && !c_cancel)); // R7

    AST_EARLY_REDIRECT_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (EARLY && any_det) |-> redirect); // R8

    AST_STATUS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (c_valid && !c_cancel && c_exc) |=> (epc == $past(c_pc)) && (cause == $past(c_cause))); // R9

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(c_valid && !c_cancel && c_exc) |=> ($stable(epc) && $stable(cause))); // R9

    AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (redirect_pc == HANDLER)); // R12

endmodule

bind exc_commit_ctrl exc_commit_ctrl_chk #(
    .HANDLER (HANDLER_PC),
    .EARLY   (EARLY_REDIRECT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .c_valid     (com_s.valid),
    .c_cancel    (com_s.cancel),
    .c_exc       (com_s.exc),
    .c_pc        (com_s.pc),
    .c_cause     (com_s.cause),
    .any_det     (any_det),
    .wb_en       (wb_en_o),
    .redirect    (redirect_o),
    .redirect_pc (redirect_pc_o),
    .epc         (epc_o),
    .cause       (cause_o)
);

// File: tb/exc_commit_ctrl_test.sv
module exc_commit_ctrl_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          NCYC       = 20;
    localparam logic [31:0] HANDLER    = 32'h0000_0100;
    localparam logic [31:0] KDATA      = 32'h5A5A_0000;
    localparam logic [31:0] NONE       = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic        if_valid  [2];
    logic [31:0] if_pc     [2];
    logic [7:0]  if_tag    [2];
    logic        if_fault  [2];
    logic        ex_ovf    [2];
    logic [31:0] ex_result [2];
    logic        mem_fault [2];
    logic        wb_en     [2];
    logic [7:0]  wb_tag    [2];
    logic [31:0] wb_data   [2];
    logic        redirect  [2];
    logic [31:0] redirect_pc [2];
    logic [31:0] epc       [2];
    logic [1:0]  cause     [2];

    int checks = 0;
    int errors = 0;

    int          ncommit [2];
    logic [31:0] cpc     [2][32];
    int          nredir  [2];
    int          first_redir [2];
    int          bad_data [2];
    int          bad_target [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_commit_ctrl #(.HANDLER_PC(HANDLER), .EARLY_REDIRECT(1'b0)) uut (
        .clk(clk), .rst(rst),
        .if_valid_i(if_valid[0]), .if_pc_i(if_pc[0]), .if_tag_i(if_tag[0]),
        .if_fault_i(if_fault[0]), .ex_ovf_i(ex_ovf[0]), .ex_result_i(ex_result[0]),
        .mem_fault_i(mem_fault[0]),
        .wb_en_o(wb_en[0]), .wb_tag_o(wb_tag[0]), .wb_data_o(wb_data[0]),
        .redirect_o(redirect[0]), .redirect_pc_o(redirect_pc[0]),
        .epc_o(epc[0]), .cause_o(cause[0])
    );

    exc_commit_ctrl #(.HANDLER_PC(HANDLER), .EARLY_REDIRECT(1'b1)) uut_early (
        .clk(clk), .rst(rst),
        .if_valid_i(if_valid[1]), .if_pc_i(if_pc[1]), .if_tag_i(if_tag[1]),
        .if_fault_i(if_fault[1]), .ex_ovf_i(ex_ovf[1]), .ex_result_i(ex_result[1]),
        .mem_fault_i(mem_fault[1]),
        .wb_en_o(wb_en[1]), .wb_tag_o(wb_tag[1]), .wb_data_o(wb_data[1]),
        .redirect_o(redirect[1]), .redirect_pc_o(redirect_pc[1]),
        .epc_o(epc[1]), .cause_o(cause[1])
    );

    task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
        end
    endtask

    task automatic idle_inputs();
        for (int d = 0; d < 2; d++) begin
            if_valid[d] = 1'b0; if_pc[d] = '0; if_tag[d] = '0; if_fault[d] = 1'b0;
            ex_ovf[d] = 1'b0; ex_result[d] = '0; mem_fault[d] = 1'b0;
        end
    endtask

    // drives both pipelines for NCYC cycles with the given fault plan
    task automatic run_case(input logic [31:0] f_if, input logic [31:0] f_ex, input logic [31:0] f_mem);
        logic [31:0] hist [2][NCYC];
        logic        seen [2];
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        for (int d = 0; d < 2; d++) begin
            ncommit[d] = 0; nredir[d] = 0; first_redir[d] = -1;
            bad_data[d] = 0; bad_target[d] = 0; seen[d] = 1'b0;
        end
        for (int c = 0; c < NCYC; c++) begin
            for (int d = 0; d < 2; d++) begin
                logic [31:0] pc;
                if (c == 0)       pc = 32'h0;
                else if (seen[d]) pc = HANDLER;
                else              pc = hist[d][c-1] + 32'd4;
                hist[d][c]   = pc;
                if_valid[d]  = 1'b1;
                if_pc[d]     = pc;
                if_tag[d]    = pc[9:2];
                if_fault[d]  = (pc == f_if);
                ex_ovf[d]    = 1'b0;
                ex_result[d] = KDATA;
                mem_fault[d] = 1'b0;
                if (c >= 2) begin
                    ex_ovf[d]    = (hist[d][c-2] == f_ex);
                    ex_result[d] = hist[d][c-2] ^ KDATA;
                end
                if (c >= 3) begin
                    mem_fault[d] = (hist[d][c-3] == f_mem);
                end
            end
            @(negedge clk);
            for (int d = 0; d < 2; d++) begin
                seen[d] = redirect[d];
                if (redirect[d]) begin
                    nredir[d]++;
                    if (first_redir[d] < 0) first_redir[d] = c;
                    if (redirect_pc[d] != HANDLER) bad_target[d]++;
                end
                if (wb_en[d]) begin
                    logic [31:0] cp;
                    cp = {22'd0, wb_tag[d], 2'b00};
                    if (ncommit[d] < 32) cpc[d][ncommit[d]] = cp;
                    if (wb_data[d] != (cp ^ KDATA)) bad_data[d]++;
                    ncommit[d]++;
                end
            end
            @(posedge clk);
            #1;
        end
        idle_inputs();
    endtask

    // common checks for a case with one taken exception at pc f
    task automatic verify(input int d, input logic [31:0] f, input logic [1:0] exp_cause,
                          input int exp_nred, input int exp_first, input string tag);
        int k;
        int bad;
        k = int'(f >> 2);
        bad = 0;
        for (int i = 0; i < k; i++) if (cpc[d][i] != 32'(i * 4)) bad++;
        chk(bad == 0 && ncommit[d] >= k, {tag, " R3 older ones commit in order"}, bad, 0);
        chk(cpc[d][k] == HANDLER, {tag, " R4 R6 first commit after older ones is handler"}, cpc[d][k], HANDLER);
        chk(cpc[d][k+1] == HANDLER + 4, {tag, " R12 handler stream commits"}, cpc[d][k+1], HANDLER + 4);
        chk(epc[d] == f, {tag, " R9 epc"}, epc[d], f);
        chk(cause[d] == exp_cause, {tag, " R9 cause"}, 32'(cause[d]), 32'(exp_cause));
        chk(nredir[d] == exp_nred, {tag, " R7 R8 redirect count"}, nredir[d], exp_nred);
        chk(first_redir[d] == exp_first, {tag, " R7 R8 redirect cycle"}, first_redir[d], exp_first);
        chk(bad_target[d] == 0, {tag, " R12 redirect target"}, bad_target[d], 0);
        chk(bad_data[d] == 0, {tag, " R1 write data"}, bad_data[d], 0);
    endtask

    task automatic t_reset();
        idle_inputs();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk(wb_en[d] == 1'b0,    "R13 wb_en in reset", 32'(wb_en[d]), 0);
            chk(redirect[d] == 1'b0, "R13 redirect in reset", 32'(redirect[d]), 0);
            chk(epc[d] == 32'h0,     "R13 epc in reset", epc[d], 0);
            chk(cause[d] == 2'd0,    "R13 cause in reset", 32'(cause[d]), 0);
        end
    endtask

    task automatic t_no_fault();
        run_case(NONE, NONE, NONE);
        for (int d = 0; d < 2; d++) begin
            int bad;
            bad = 0;
            for (int i = 0; i < ncommit[d] && i < 32; i++) if (cpc[d][i] != 32'(i * 4)) bad++;
            chk(ncommit[d] == NCYC - 4, "R1 commit count four cycles behind fetch", ncommit[d], NCYC - 4);
            chk(bad == 0, "R1 program order", bad, 0);
            chk(bad_data[d] == 0, "R1 result data", bad_data[d], 0);
            chk(nredir[d] == 0, "R2 no redirect without fault", nredir[d], 0);
            chk(epc[d] == 0 && cause[d] == 0, "R9 status untouched", epc[d], 0);
        end
    endtask

    task automatic t_fetch_fault();
        run_case(32'h14, NONE, NONE);
        verify(0, 32'h14, 2'd0, 1, 9, "fetch fault late");
        verify(1, 32'h14, 2'd0, 1, 5, "fetch fault early");
    endtask

    task automatic t_overflow();
        run_case(NONE, 32'h10, NONE);
        verify(0, 32'h10, 2'd1, 1, 8, "overflow late");
        verify(1, 32'h10, 2'd1, 1, 6, "overflow early");
    endtask

    task automatic t_data_fault();
        run_case(NONE, NONE, 32'h0C);
        verify(0, 32'h0C, 2'd2, 1, 7, "data fault late");
        verify(1, 32'h0C, 2'd2, 1, 6, "data fault early");
    endtask

    // R10: data fault on 0x08 and overflow on 0x0C hit in the same cycle
    task automatic t_same_cycle();
        run_case(NONE, 32'h0C, 32'h08);
        verify(0, 32'h08, 2'd2, 1, 6, "R10 priority late");
        verify(1, 32'h08, 2'd2, 1, 5, "R10 priority early");
    endtask

    // R11: younger fetch fault on 0x10, then older overflow on 0x0C one cycle later
    task automatic t_override();
        run_case(32'h10, 32'h0C, NONE);
        verify(0, 32'h0C, 2'd1, 1, 7, "R11 override late");
        verify(1, 32'h0C, 2'd1, 2, 4, "R11 override early");
        chk(ncommit[1] >= 5, "R11 R5 cancelled younger skipped", ncommit[1], 5);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_no_fault();
        t_fetch_fault();
        t_overflow();
        t_data_fault();
        t_same_cycle();
        t_override();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule